// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a word-addressed scratchpad split into 32 banks of 32-bit words. It serves one warp-wide request at a time. A request carries one word address per lane for 32 lanes, a lane-enable mask, a read/write flag and one write word per lane. The low address bits choose a bank and the upper bits choose a row within that bank. In each clock cycle a bank can serve one row. All pending lanes that ask for that exact row are served together in that cycle.

When active lanes ask a bank for different rows, the block spreads the request over successive cycles. It uses as few cycles as it can: the largest number of distinct rows that any single bank receives. While it works through a request it raises busy and ignores new requests. When the request is complete it raises done for one cycle. At that point the read words for all lanes and the number of service cycles are both valid, and they stay valid until the next request is accepted. This count exposes the conflict degree of the access pattern. A column walk with a row pitch equal to the bank count costs one cycle per lane. A pitch one word larger costs a single cycle.

Top module: `spad_banked`

## Requirements
- R1: A lane's word address `a` maps to bank `a mod 32` (address bits [4:0]) and row `a / 32` (bits [9:5]). Lanes whose addresses fall in distinct banks are all served in one cycle.
- R2: Each bank serves at most one row per cycle, so lanes that ask one bank for different rows are served in successive cycles. In each round, every bank serves the row of its lowest-numbered pending lane. Done rises D+1 clock edges after the accepting edge, where D is the value reported on `cycles`.
- R3: Active lanes that read the same address are all served in the same cycle, and every one of them receives the stored word.
- R4: When done is high, `cycles` equals the maximum over banks of the number of distinct addresses that active lanes requested in that bank. This is 32 when all lanes hit different rows of one bank. An empty mask gives 0, and done then rises one edge after acceptance.
- R5: When several active lanes write the same address, the stored word is the one from the highest-numbered of those lanes.
- R6: Lanes whose mask bit is 0 write nothing. In the returned read data, their 32-bit field is zero.
- R7: While busy is high, `req_valid` is ignored. A write presented during that time changes no memory word and does not alter the result of the request in progress.
- R8: Done is a single-cycle pulse and is low while busy is high. `rd_data` (lane `i` in bits [32i+31:32i]) and `cycles` hold their values from done until the next request is accepted.
- R9: A column of 32 addresses with pitch 32 takes 32 cycles. The same column with pitch 33 takes 1 cycle.
- R10: After reset, busy and done are low, and `cycles` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted on an edge where busy is low |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_mask | input | 32 | Lane enables, bit i for lane i |
| req_addr | input | 320 | Lane word addresses, lane i in bits [10i+9:10i] |
| req_wdata | input | 1024 | Lane write words, lane i in bits [32i+31:32i] |
| busy | output | 1 | Request being served; new requests ignored |
| done | output | 1 | One-cycle pulse when the request is complete |
| rd_data | output | 1024 | Per-lane read words, valid from done |
| cycles | output | 6 | Number of service cycles of the last request |

## Verification
The hardest situation to reach from the ports is a second request that arrives while a long, fully conflicting request is still being served. The bench launches a 32-way column read and then holds a full-mask write to a separate, pre-filled region on the request inputs for several busy cycles. It releases that write before busy falls. A later read of the region shows whether any word changed, and the monitor checks that the column result itself was not disturbed. The bench also mixes duplicate and distinct rows within one bank to confirm that the cycle count follows distinct addresses rather than lane counts.

// File: rtl/spad_pkg.sv
package spad_pkg;
    localparam int unsigned DEF_LANES = 32;
    localparam int unsigned DEF_BANKS = 32;
    localparam int unsigned DEF_ROWS  = 32;
    localparam int unsigned DEF_DW    = 32;
endpackage

// File: rtl/spad_bank_pick.sv
// Per-bank round selector: chooses the row of the lowest pending lane that
// maps to this bank, and marks every pending lane that asks for that row.
module spad_bank_pick #(
    parameter int unsigned LANES   = 32,
    parameter int unsigned AW      = 10,
    parameter int unsigned BW      = 5,
    parameter int unsigned DW      = 32,
    parameter int unsigned BANK_ID = 0
) (
    input  logic [LANES-1:0]         pending,
    input  logic [LANES-1:0][AW-1:0] lane_addr,
    input  logic [LANES-1:0][DW-1:0] lane_wdata,
    output logic [LANES-1:0]         serve,
    output logic                     hit,
    output logic [AW-BW-1:0]         row,
    output logic [DW-1:0]            wdata_win
);
    logic          found;
    logic [AW-1:0] lead;

    always_comb begin
        found = 1'b0;
        lead  = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!found && pending[l] && lane_addr[l][BW-1:0] == BW'(BANK_ID)) begin
                found = 1'b1;
                lead  = lane_addr[l];
            end
        end
    end

    always_comb begin
        serve     = '0;
        wdata_win = '0;
        for (int l = 0; l < LANES; l++) begin
            if (found && pending[l] && lane_addr[l] == lead) begin
                serve[l]  = 1'b1;
                wdata_win = lane_wdata[l];   // later lanes override: highest wins
            end
        end
    end

    assign hit = found;
    assign row = lead[AW-1:BW];
endmodule

// File: rtl/spad_bank_mem.sv
// One bank: single row per cycle, write on the edge, read combinational.
module spad_bank_mem #(
    parameter int unsigned ROWS = 32,
    parameter int unsigned DW   = 32,
    localparam int unsigned RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [ROWS];

    always_ff @(posedge clk) begin
        if (we) mem_q[row] <= wdata;
    end

    assign rdata = mem_q[row];
endmodule

// File: rtl/spad_banked.sv
module spad_banked
    import spad_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned BANKS = DEF_BANKS,
    parameter int unsigned ROWS  = DEF_ROWS,
    parameter int unsigned DW    = DEF_DW
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    input  logic                                   req_write,
    input  logic [LANES-1:0]                       req_mask,
    input  logic [LANES*$clog2(BANKS*ROWS)-1:0]    req_addr,
    input  logic [LANES*DW-1:0]                    req_wdata,
    output logic                                   busy,
    output logic                                   done,
    output logic [LANES*DW-1:0]                    rd_data,
    output logic [$clog2(LANES+1)-1:0]             cycles
);
    localparam int unsigned AW = $clog2(BANKS*ROWS);
    localparam int unsigned BW = $clog2(BANKS);
    localparam int unsigned RW = AW - BW;
    localparam int unsigned CW = $clog2(LANES+1);

    typedef struct packed {
        logic                     busy;
        logic                     done;
        logic                     wr;
        logic [LANES-1:0]         pend;
        logic [LANES-1:0][AW-1:0] addr;
        logic [LANES-1:0][DW-1:0] wd;
        logic [LANES-1:0][DW-1:0] rd;
        logic [CW-1:0]            cyc;
    } st_t;

    st_t st_d, st_q;

    logic [BANKS-1:0][LANES-1:0] bank_serve;
    logic [BANKS-1:0]            bank_hit;
    logic [BANKS-1:0][RW-1:0]    bank_row;
    logic [BANKS-1:0][DW-1:0]    bank_wd;
    logic [BANKS-1:0][DW-1:0]    bank_rd;
    logic [LANES-1:0]            served;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        spad_bank_pick #(
            .LANES(LANES), .AW(AW), .BW(BW), .DW(DW), .BANK_ID(b)
        ) u_pick (
            .pending   (st_q.pend),
            .lane_addr (st_q.addr),
            .lane_wdata(st_q.wd),
            .serve     (bank_serve[b]),
            .hit       (bank_hit[b]),
            .row       (bank_row[b]),
            .wdata_win (bank_wd[b])
        );

        spad_bank_mem #(.ROWS(ROWS), .DW(DW)) u_mem (
            .clk  (clk),
            .we   (st_q.busy && st_q.wr && bank_hit[b]),
            .row  (bank_row[b]),
            .wdata(bank_wd[b]),
            .rdata(bank_rd[b])
        );
    end

    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) served = served | bank_serve[b];
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.wr   = req_write;
                st_d.pend = req_mask;
                for (int l = 0; l < LANES; l++) begin
                    st_d.addr[l] = req_addr[l*AW +: AW];
                    st_d.wd[l]   = req_wdata[l*DW +: DW];
                end
                st_d.rd   = '0;
                st_d.cyc  = '0;
                st_d.busy = |req_mask;
                st_d.done = ~|req_mask;
            end
        end else begin
            st_d.cyc  = st_q.cyc + 1'b1;
            st_d.pend = st_q.pend & ~served;
            for (int l = 0; l < LANES; l++) begin
                if (served[l] && !st_q.wr)
                    st_d.rd[l] = bank_rd[st_q.addr[l][BW-1:0]];
            end
            if (st_d.pend == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign rd_data = st_q.rd;
    assign cycles  = st_q.cyc;

    // Every round retires at least one lane (R2)
    p_progress_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $countones(st_q.pend) < $past($countones(st_q.pend)));

    // Bank selectors only serve lanes still pending (R2)
    p_serve_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (served & ~st_q.pend) == '0);

    // Completion count never exceeds the lane count (R4)
    p_cycles_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cycles <= CW'(LANES));

    // Request held stable while busy (R7)
    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.wr) && $stable(st_q.addr) && $stable(st_q.wd));

    // Done is a lone pulse and never overlaps busy (R8)
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/spad_banked_bench.sv
module spad_banked_bench;
    localparam int LANES = 32;
    localparam int DW    = 32;
    localparam int AW    = 10;
    localparam int CW    = 6;
    localparam int NB    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [LANES-1:0]    req_mask = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES*DW-1:0] req_wdata = '0;
    logic busy, done;
    logic [LANES*DW-1:0] rd_data;
    logic [CW-1:0] cycles;

    always #2 clk = ~clk;

    spad_banked u_spad_banked (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .cycles(cycles)
    );

    typedef struct {
        int acc;
        int lat;
        int cyc;
        logic [LANES*DW-1:0] rd;
        string tag;
    } exp_t;

    exp_t q[$];
    int errors = 0, checks = 0, cnt = 0;
    bit finished = 0;
    logic [DW-1:0] model [1024];
    int ad [LANES];
    logic [DW-1:0] wv [LANES];
    logic [LANES-1:0] mk;

    always @(posedge clk) cnt <= cnt + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare completions against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                chk(0, "R8", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                int bad;
                e = q.pop_front();
                chk(cycles == CW'(e.cyc), e.tag, "cycles", cycles, e.cyc);
                chk(cnt - e.acc == e.lat, "R2", "done latency", cnt - e.acc, e.lat);
                bad = -1;
                for (int l = LANES-1; l >= 0; l--)
                    if (rd_data[l*DW +: DW] !== e.rd[l*DW +: DW]) bad = l;
                if (bad >= 0)
                    chk(0, e.tag, $sformatf("rd lane %0d", bad),
                        rd_data[bad*DW +: DW], e.rd[bad*DW +: DW]);
                else
                    chk(1, e.tag, "rd", 0, 0);
            end
        end
    end

    function automatic int degree();
        int mx = 0;
        for (int b = 0; b < NB; b++) begin
            int n = 0;
            for (int i = 0; i < LANES; i++) begin
                bit dup = 0;
                if (mk[i] && (ad[i] % NB) == b) begin
                    for (int j = 0; j < i; j++)
                        if (mk[j] && ad[j] == ad[i]) dup = 1;
                    if (!dup) n++;
                end
            end
            if (n > mx) mx = n;
        end
        return mx;
    endfunction

    // Driver: build expectation, apply to model, launch request.
    // intrude > 0 presents a stray write for that many busy cycles (R7).
    task automatic issue(input bit wr, input string tag, input int intrude);
        exp_t e;
        int d;
        d = degree();
        e.cyc = d;
        e.lat = (d == 0) ? 1 : d + 1;
        e.tag = tag;
        e.rd  = '0;
        for (int l = 0; l < LANES; l++)
            if (!wr && mk[l]) e.rd[l*DW +: DW] = model[ad[l]];
        if (wr)
            for (int l = 0; l < LANES; l++)
                if (mk[l]) model[ad[l]] = wv[l];
        @(negedge clk);
        while (busy) @(negedge clk);
        req_write = wr;
        req_mask  = mk;
        for (int l = 0; l < LANES; l++) begin
            req_addr[l*AW +: AW]  = AW'(ad[l]);
            req_wdata[l*DW +: DW] = wv[l];
        end
        req_valid = 1'b1;
        e.acc = cnt;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude > 0) begin
            req_write = 1'b1;
            req_mask  = '1;
            for (int l = 0; l < LANES; l++) begin
                req_addr[l*AW +: AW]  = AW'(100 + l);
                req_wdata[l*DW +: DW] = 32'hDEAD_0000 + l;
            end
            req_valid = 1'b1;
            for (int k = 0; k < intrude; k++) begin
                chk(busy == 1'b1, "R7", "busy during service", busy, 1);
                @(negedge clk);
            end
            req_valid = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(busy == 0, "R10", "busy", busy, 0);
        chk(done == 0, "R10", "done", done, 0);
        chk(cycles == 0, "R10", "cycles", cycles, 0);
        chk(rd_data == '0, "R10", "rd_data", rd_data[31:0], 0);

        // R1: unit stride, one lane per bank
        mk = '1;
        for (int i = 0; i < LANES; i++) begin ad[i] = i; wv[i] = 32'hA100_0000 + i; end
        issue(1, "R1", 0);
        issue(0, "R1", 0);

        // R9: pitch 32 column, one bank
        for (int i = 0; i < LANES; i++) begin ad[i] = i * 32; wv[i] = 32'hB200_0000 + i; end
        issue(1, "R9", 0);
        issue(0, "R9", 0);

        // R9: pitch 33 column spreads across banks
        for (int i = 0; i < LANES; i++) begin ad[i] = i * 33; wv[i] = 32'hC300_0000 + i; end
        issue(1, "R9", 0);
        issue(0, "R9", 0);

        // R3: broadcast read of one address
        for (int i = 0; i < LANES; i++) ad[i] = 5;
        issue(0, "R3", 0);

        // R5: all lanes write one address; then read it back
        for (int i = 0; i < LANES; i++) begin ad[i] = 7; wv[i] = 32'hD400_0000 + i; end
        issue(1, "R5", 0);
        chk(model[7] == 32'hD400_001F, "R5", "model winner", model[7], 32'hD400_001F);
        mk = '1;
        for (int i = 0; i < LANES; i++) ad[i] = 7;
        issue(0, "R5", 0);

        // R6: sparse mask write, inactive lanes aim at filled words
        mk = 32'h5555_5555;
        for (int i = 0; i < LANES; i++) begin ad[i] = i; wv[i] = 32'hE500_0000 + i; end
        issue(1, "R6", 0);
        issue(0, "R6", 0);     // inactive lanes must read 0
        mk = '1;
        issue(0, "R6", 0);     // odd lanes keep earlier words

        // R4: empty mask
        mk = '0;
        issue(0, "R4", 0);

        // R4: mixed duplicates and distinct rows in one bank
        mk = '1;
        for (int i = 0; i < LANES; i++) begin
            ad[i] = (i < 8) ? 3 + 32 * (i / 2) : 200 + i;
            wv[i] = 32'hF600_0000 + i;
        end
        issue(1, "R4", 0);
        issue(0, "R4", 0);

        // R7: stray write while a long read is in flight
        for (int i = 0; i < LANES; i++) begin ad[i] = 100 + i; wv[i] = 32'h1700_0000 + i; end
        issue(1, "R7", 0);
        for (int i = 0; i < LANES; i++) ad[i] = i * 32;
        issue(0, "R7", 6);
        for (int i = 0; i < LANES; i++) ad[i] = 100 + i;
        issue(0, "R7", 0);

        // R8: result holds after done
        repeat (3) @(negedge clk);
        chk(done == 0, "R8", "done low after pulse", done, 0);
        chk(rd_data[31:0] == 32'h1700_0000, "R8", "rd held", rd_data[31:0], 32'h1700_0000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule